// File: doc/BRIEF.md
# Coefficient Shift Residue Generator

This block sits at the coefficient input of a residue-number multiply-accumulate datapath. The datapath stores filter coefficients in a compact pseudo-floating-point word. Each word carries a small exponent-like shift and a normalized magnitude. The magnitude's leading one is not stored. The block splits the word into its two fields and puts the hidden one back on the magnitude. For every modulus channel of the datapath, it then produces the residue of two raised to the shift. A downstream modular multiplier applies the shift with that residue, so no wide barrel shifter is needed.

Each channel's exponentiation circuit is chosen when the block is built, from the form of its modulus. A pure power of two gives a one-hot value that falls to zero once the shift reaches the width. One less than a power of two gives a rotating one-hot value. One more than a power of two gives a power of two or its complement. Modulus 23 uses a few gates on the upper shift bits and a four-way selection on the lower two bits. Any other modulus uses a sixteen-entry table that is computed at elaboration. One reserved code stands for a zero coefficient, and it clears every output. An optional register stage, with a valid flag, retimes the results.

Top module: `pfp_shift_residue`

## Requirements
- R1: The 11-bit coefficient word holds the 4-bit shift in bits 10:7 and the stored 7-bit magnitude in bits 6:0; bits 6:0 of `out_nval` equal the stored magnitude for every non-zero code.
- R2: For a non-zero code, `out_nval` bit 7 is one (the restored hidden leading one).
- R3: The word is the zero code exactly when bits 10:6 are all ones. For the zero code, `out_zero` is one and `out_nval` and every residue are zero. For any other code, `out_zero` is zero.
- R4: The modulus-32 lane gives 2^s for shift s below 5, and 0 from 5 upward.
- R5: The modulus-31 lane gives 2^(s mod 5).
- R6: The modulus-17 lane gives 2^(s mod 4) when floor(s/4) is even, and 17 minus that value when it is odd.
- R7: The modulus-23 lane gives 2^s mod 23 for every shift from 0 to 15.
- R8: The lanes for moduli 29, 27, 25 and 19 give 2^s mod m for every shift from 0 to 15.
- R9: Every residue is fully reduced, that is, strictly below its own modulus.
- R10: With the register stage enabled, outputs appear one clock after the inputs, and `out_valid` equals `in_valid` of the previous cycle. While `rst_n` is low, `out_valid`, `out_zero`, `out_nval` and `out_res` are all zero.
- R11: Lane i occupies `out_res[5i+4:5i]`. The default lane order is 32, 31, 29, 27, 25, 23, 19, 17 for lanes 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient word is valid |
| coef_in | input | 11 | Packed coefficient: shift in bits 10:7, stored magnitude in bits 6:0 |
| out_valid | output | 1 | Results are valid |
| out_zero | output | 1 | The zero code was decoded |
| out_nval | output | 8 | Magnitude with the hidden one restored; zero for the zero code |
| out_res | output | 40 | One 5-bit residue of 2^shift per modulus lane |

## Verification
The bench uses the default build: eight moduli in the default lane order, a 4-bit shift and the register stage enabled. This one build instantiates every exponentiation variant: plain, rotating, complemented, the gate-level modulus-23 circuit and the computed table. Because the shift is only four bits wide, all sixteen shift values can be swept on every lane and checked against 2^s mod m computed directly. The sweep is repeated with several magnitudes. Codes next to the zero code are also exercised, to confirm that only the exact reserved pattern clears the outputs.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

  localparam int unsigned PFP_SHIFT_W = 4;
  localparam int unsigned PFP_NVAL_W  = 7;
  localparam int unsigned PFP_RES_W   = 5;
  localparam int unsigned PFP_MOD_W   = 8;

  // Which exponentiation circuit a modulus lane receives.
  typedef enum logic [2:0] {
    EXP_PLAIN    = 3'd0,  // m = 2^n
    EXP_MERSENNE = 3'd1,  // m = 2^n - 1
    EXP_FERMAT   = 3'd2,  // m = 2^n + 1
    EXP_GATE23   = 3'd3,  // m = 23, gate-level form
    EXP_TABLE    = 3'd4   // anything else, computed table
  } exp_kind_e;

  function automatic bit is_pow2(int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int unsigned log2_of(int unsigned v);
    int unsigned n;
    n = 0;
    for (int k = 0; k < 31; k++) begin
      if ((32'd1 << k) == v) n = k;
    end
    return n;
  endfunction

  function automatic exp_kind_e kind_of(int unsigned m, int unsigned shift_w);
    if (m == 23 && shift_w == 4) return EXP_GATE23;
    if (is_pow2(m))              return EXP_PLAIN;
    if (is_pow2(m + 1))          return EXP_MERSENNE;
    if (m > 2 && is_pow2(m - 1)) return EXP_FERMAT;
    return EXP_TABLE;
  endfunction

  function automatic int unsigned exp_n_of(int unsigned m, exp_kind_e k);
    case (k)
      EXP_PLAIN:    return log2_of(m);
      EXP_MERSENNE: return log2_of(m + 1);
      EXP_FERMAT:   return log2_of(m - 1);
      default:      return 1;
    endcase
  endfunction

  // 2^s mod 2^n: the one-hot value until it shifts out of range.
  function automatic int unsigned pow2_plain(int unsigned s, int unsigned n);
    return (s < n) ? (32'd1 << s) : 32'd0;
  endfunction

  // 2^s mod (2^n - 1): since 2^n == 1, the one rotates.
  function automatic int unsigned pow2_mersenne(int unsigned s, int unsigned n);
    return 32'd1 << (s % n);
  endfunction

  // 2^s mod (2^n + 1): since 2^n == -1, odd blocks of n are complemented.
  function automatic int unsigned pow2_fermat(int unsigned s, int unsigned n, int unsigned m);
    int unsigned p;
    p = 32'd1 << (s % n);
    return ((s / n) % 2 == 1) ? (m - p) : p;
  endfunction

  // Repeated doubling, used only at elaboration to fill tables.
  function automatic int unsigned pow2_mod_iter(int unsigned s, int unsigned m);
    int unsigned acc;
    acc = 1 % m;
    for (int unsigned k = 0; k < s; k++) acc = (acc * 2) % m;
    return acc;
  endfunction

  // 2^s mod 23: upper bits choose a base of 1, 16, 3 or 2;
  // the low two bits choose the doubled and reduced variant.
  function automatic logic [4:0] pow2_gate23(logic [3:0] s);
    logic a, b;
    logic [4:0] r;
    a = s[3];
    b = s[2];
    case (s[1:0])
      2'd0:    r = {~a & b, 1'b0,   1'b0,   a,      ~b};
      2'd1:    r = {1'b0,   ~a & b, a,      ~b,     ~a & b};
      2'd2:    r = {~a & b, a,      ~b,     ~a & b, 1'b0};
      default: r = {a & b,  ~a,     ~a & b, 1'b0,   a ^ b};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pfp_field_split.sv
module pfp_field_split #(
  parameter int unsigned SHIFT_W = pfp_pkg::PFP_SHIFT_W,
  parameter int unsigned NVAL_W  = pfp_pkg::PFP_NVAL_W,
  localparam int unsigned COEF_W = SHIFT_W + NVAL_W
) (
  input  logic [COEF_W-1:0]  coef,
  output logic [SHIFT_W-1:0] shift,
  output logic               zero_hit,
  output logic [NVAL_W:0]    nval_full
);

  logic [NVAL_W-1:0] nval_field;

  assign shift      = coef[COEF_W-1 -: SHIFT_W];
  assign nval_field = coef[NVAL_W-1:0];

  // The reserved code is the maximum shift combined with a set top magnitude bit.
  assign zero_hit  = (&shift) & nval_field[NVAL_W-1];
  assign nval_full = zero_hit ? '0 : {1'b1, nval_field};

endmodule

// File: rtl/pfp_exp_lane.sv
module pfp_exp_lane #(
  parameter int unsigned MODULUS = 23,
  parameter int unsigned SHIFT_W = pfp_pkg::PFP_SHIFT_W,
  parameter int unsigned RES_W   = pfp_pkg::PFP_RES_W
) (
  input  logic [SHIFT_W-1:0] shift,
  input  logic               kill,
  output logic [RES_W-1:0]   res
);
  import pfp_pkg::*;

  localparam exp_kind_e   KIND  = kind_of(MODULUS, SHIFT_W);
  localparam int unsigned EXP_N = exp_n_of(MODULUS, KIND);
  localparam int unsigned DEPTH = 1 << SHIFT_W;

  function automatic logic [DEPTH*RES_W-1:0] build_table();
    logic [DEPTH*RES_W-1:0] t;
    t = '0;
    for (int unsigned k = 0; k < DEPTH; k++) begin
      t[k*RES_W +: RES_W] = RES_W'(pow2_mod_iter(k, MODULUS));
    end
    return t;
  endfunction

  logic [RES_W-1:0] raw_res;

  generate
    if (KIND == EXP_PLAIN) begin : g_plain
      always_comb raw_res = RES_W'(pow2_plain(32'(shift), EXP_N));
    end else if (KIND == EXP_MERSENNE) begin : g_mersenne
      always_comb raw_res = RES_W'(pow2_mersenne(32'(shift), EXP_N));
    end else if (KIND == EXP_FERMAT) begin : g_fermat
      always_comb raw_res = RES_W'(pow2_fermat(32'(shift), EXP_N, MODULUS));
    end else if (KIND == EXP_GATE23) begin : g_gate23
      logic [4:0] g23;
      always_comb g23 = pow2_gate23(shift[3:0]);
      always_comb raw_res = RES_W'(g23);
    end else begin : g_table
      localparam logic [DEPTH*RES_W-1:0] TBL = build_table();
      always_comb raw_res = TBL[32'(shift)*RES_W +: RES_W];
    end
  endgenerate

  assign res = kill ? '0 : raw_res;

endmodule

// File: rtl/pfp_out_stage.sv
module pfp_out_stage #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] d,
  output logic         out_valid,
  output logic [W-1:0] q
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          q         <= '0;
        end else begin
          out_valid <= in_valid;
          q         <= d;
        end
      end
    end else begin : g_pass
      assign out_valid = in_valid;
      assign q         = d;
    end
  endgenerate

endmodule

// File: rtl/pfp_shift_residue.sv
module pfp_shift_residue #(
  parameter int unsigned SHIFT_W = pfp_pkg::PFP_SHIFT_W,
  parameter int unsigned NVAL_W  = pfp_pkg::PFP_NVAL_W,
  parameter int unsigned RES_W   = pfp_pkg::PFP_RES_W,
  parameter int unsigned NUM_MOD = 8,
  parameter logic [NUM_MOD*pfp_pkg::PFP_MOD_W-1:0] MOD_LIST =
    {8'd17, 8'd19, 8'd23, 8'd25, 8'd27, 8'd29, 8'd31, 8'd32},
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned COEF_W = SHIFT_W + NVAL_W,
  localparam int unsigned MOD_W  = pfp_pkg::PFP_MOD_W,
  localparam int unsigned BUS_W  = NUM_MOD * RES_W,
  localparam int unsigned PACK_W = 1 + (NVAL_W + 1) + BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [COEF_W-1:0] coef_in,
  output logic              out_valid,
  output logic              out_zero,
  output logic [NVAL_W:0]   out_nval,
  output logic [BUS_W-1:0]  out_res
);

  logic [SHIFT_W-1:0] shift_val;
  logic               zero_hit;
  logic [NVAL_W:0]    nval_full;
  logic [BUS_W-1:0]   lane_res;
  logic [PACK_W-1:0]  pack_d;
  logic [PACK_W-1:0]  pack_q;

  pfp_field_split #(
    .SHIFT_W (SHIFT_W),
    .NVAL_W  (NVAL_W)
  ) u_split (
    .coef      (coef_in),
    .shift     (shift_val),
    .zero_hit  (zero_hit),
    .nval_full (nval_full)
  );

  generate
    for (genvar i = 0; i < NUM_MOD; i++) begin : g_lane
      localparam int unsigned M_I = int'(MOD_LIST[i*MOD_W +: MOD_W]);
      pfp_exp_lane #(
        .MODULUS (M_I),
        .SHIFT_W (SHIFT_W),
        .RES_W   (RES_W)
      ) u_lane (
        .shift (shift_val),
        .kill  (zero_hit),
        .res   (lane_res[i*RES_W +: RES_W])
      );
    end
  endgenerate

  assign pack_d = {zero_hit, nval_full, lane_res};

  pfp_out_stage #(
    .W       (PACK_W),
    .REG_OUT (REG_OUT)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .d         (pack_d),
    .out_valid (out_valid),
    .q         (pack_q)
  );

  assign out_zero = pack_q[PACK_W-1];
  assign out_nval = pack_q[BUS_W +: NVAL_W+1];
  assign out_res  = pack_q[BUS_W-1:0];

endmodule

// File: rtl/pfp_shift_residue_chk.sv
module pfp_shift_residue_chk #(
  parameter int unsigned SHIFT_W = 4,
  parameter int unsigned NVAL_W  = 7,
  parameter int unsigned RES_W   = 5,
  parameter int unsigned NUM_MOD = 8,
  parameter logic [NUM_MOD*8-1:0] MOD_LIST = '0,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned COEF_W = SHIFT_W + NVAL_W,
  localparam int unsigned BUS_W  = NUM_MOD * RES_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [COEF_W-1:0] coef_in,
  input logic              out_valid,
  input logic              out_zero,
  input logic [NVAL_W:0]   out_nval,
  input logic [BUS_W-1:0]  out_res
);
  import pfp_pkg::*;

  // R3: a zero result carries no magnitude and no residue
  assert_zero_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_res == '0 && out_nval == '0));

  // R2: any non-zero result carries the restored leading one
  assert_hidden_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zero) |-> out_nval[NVAL_W]);

  generate
    if (REG_OUT) begin : g_seq
      // R10: valid follows the input one cycle later
      assert_valid_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      assert_idle_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R3: the reserved code is flagged in the next cycle
      assert_zero_detect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&coef_in[COEF_W-1:NVAL_W-1])) |=> out_zero);
      // R1: the stored magnitude reaches the output unchanged
      assert_field_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(&coef_in[COEF_W-1:NVAL_W-1])) |=>
          (!out_zero && out_nval[NVAL_W-1:0] == $past(coef_in[NVAL_W-1:0])));
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_MOD; i++) begin : g_lane_chk
      localparam int unsigned M_I = int'(MOD_LIST[i*8 +: 8]);
      localparam exp_kind_e   K_I = kind_of(M_I, SHIFT_W);
      // R9: each lane stays below its modulus
      assert_reduced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, out_res[i*RES_W +: RES_W]} < (RES_W+1)'(M_I)));
      if (K_I == EXP_PLAIN) begin : g_plain_chk
        // R4: power-of-two modulus gives at most one set bit
        assert_plain_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> $onehot0(out_res[i*RES_W +: RES_W]));
      end else if (K_I == EXP_MERSENNE) begin : g_mers_chk
        // R5: one-below-power modulus gives exactly one set bit unless zeroed
        assert_mers_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
          (out_valid && !out_zero) |-> ($countones(out_res[i*RES_W +: RES_W]) == 1));
      end
    end
  endgenerate

endmodule

bind pfp_shift_residue pfp_shift_residue_chk #(
  .SHIFT_W  (SHIFT_W),
  .NVAL_W   (NVAL_W),
  .RES_W    (RES_W),
  .NUM_MOD  (NUM_MOD),
  .MOD_LIST (MOD_LIST),
  .REG_OUT  (REG_OUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .coef_in   (coef_in),
  .out_valid (out_valid),
  .out_zero  (out_zero),
  .out_nval  (out_nval),
  .out_res   (out_res)
);

// File: tb/sim_pfp_shift_residue.sv
module sim_pfp_shift_residue;

  localparam int NLANE = 8;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [10:0] coef_in;
  logic        out_valid;
  logic        out_zero;
  logic [7:0]  out_nval;
  logic [39:0] out_res;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // R11: expected lane order, lane 0 first
  int mods [NLANE] = '{32, 31, 29, 27, 25, 23, 19, 17};

  pfp_shift_residue #(.REG_OUT(1'b1)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .coef_in   (coef_in),
    .out_valid (out_valid),
    .out_zero  (out_zero),
    .out_nval  (out_nval),
    .out_res   (out_res)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string lane_tag(int m);
    case (m)
      32:      return "R4";
      31:      return "R5";
      17:      return "R6";
      23:      return "R7";
      default: return "R8";
    endcase
  endfunction

  // Drive at the falling edge; look after the next rising edge.
  task automatic apply(input logic v, input logic [10:0] c);
    @(negedge clk);
    in_valid = v;
    coef_in  = c;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_word(input logic [10:0] c);
    int s;
    bit z;
    logic [39:0] exp_bus;
    s = int'(c[10:7]);
    z = (c[10:7] == 4'hf) && c[6];
    exp_bus = '0;
    chk("R3 zero flag", 64'(out_zero), 64'(z));
    if (z) begin
      chk("R3 nval cleared", 64'(out_nval), 64'd0);
      chk("R3 residues cleared", 64'(out_res), 64'd0);
    end else begin
      chk("R1 stored magnitude", 64'(out_nval[6:0]), 64'(c[6:0]));
      chk("R2 hidden one", 64'(out_nval[7]), 64'd1);
      for (int i = 0; i < NLANE; i++) begin
        int e;
        e = (1 << s) % mods[i];
        exp_bus[i*5 +: 5] = 5'(e);
        chk($sformatf("%s lane m=%0d s=%0d", lane_tag(mods[i]), mods[i], s),
            64'(out_res[i*5 +: 5]), 64'(e));
        chk($sformatf("R9 reduced m=%0d", mods[i]),
            64'(int'(out_res[i*5 +: 5]) < mods[i]), 64'd1);
      end
      chk("R11 packed lane order", 64'(out_res), 64'(exp_bus));
    end
  endtask

  task automatic t_reset();
    rst_n    = 1'b0;
    in_valid = 1'b1;
    coef_in  = 11'h0a5;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset valid", 64'(out_valid), 64'd0);
    chk("R10 reset zero", 64'(out_zero), 64'd0);
    chk("R10 reset nval", 64'(out_nval), 64'd0);
    chk("R10 reset res", 64'(out_res), 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b1;
  endtask

  task automatic t_sweep();
    logic [6:0] mags [4] = '{7'h00, 7'h15, 7'h40, 7'h3f};
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 16; s++) begin
        logic [10:0] c;
        c = {4'(s), mags[m]};
        apply(1'b1, c);
        chk("R10 valid follows", 64'(out_valid), 64'd1);
        expect_word(c);
      end
    end
  endtask

  task automatic t_zero_codes();
    // R3: only bits 10:6 all ones is the zero code
    logic [10:0] codes [5] = '{11'h7ff, 11'h7c0, 11'h7bf, 11'h77f, 11'h73f};
    for (int k = 0; k < 5; k++) begin
      apply(1'b1, codes[k]);
      expect_word(codes[k]);
    end
  endtask

  task automatic t_valid_pattern();
    logic pat [6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    for (int k = 0; k < 6; k++) begin
      apply(pat[k], 11'h155);
      chk("R10 valid one cycle later", 64'(out_valid), 64'(pat[k]));
    end
  endtask

  task automatic t_mid_reset();
    apply(1'b1, 11'h3a1);
    chk("R10 valid before reset", 64'(out_valid), 64'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async clear valid", 64'(out_valid), 64'd0);
    chk("R10 async clear nval", 64'(out_nval), 64'd0);
    chk("R10 async clear res", 64'(out_res), 64'd0);
    @(negedge clk);
    rst_n    = 1'b1;
    in_valid = 1'b0;
    apply(1'b1, 11'h3a1);
    expect_word(11'h3a1);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_zero_codes();
    t_valid_pattern();
    t_mid_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule